// File: doc/BRIEF.md
# Floating-Point Operand Unpacker to a Widened Internal Format

This block accepts one IEEE 754 operand per cycle, either single precision (binary32) or double precision (binary64), and rewrites it into a single internal representation. That representation has a sign bit, a 12-bit exponent biased by 2047, and a 52-bit fraction with a hidden leading one. Both source formats pass through the same field-splitting and normalising path. A single-precision fraction is placed at the top of the 52-bit field.

The internal exponent is wider than either source exponent, so every subnormal input can be written as a normal number. A leading-zero count finds how far the fraction must move so that its first one becomes the hidden bit. The fraction is shifted by that amount and the exponent is lowered by it. Downstream arithmetic therefore never sees a subnormal operand.

Zero, infinity and NaN are each given a fixed exponent pattern. They are also reported on class flags, which separate quiet NaNs from signalling NaNs. The result is registered and appears one clock after the operand is presented.

Top module: `fpx_unpack`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise. Synchronous active-high `rst` clears `out_valid`, `out_sign`, `out_exp`, `out_mant` and all class flags to 0.
- R2: `in_dbl`=1 selects double precision (sign bit 63, exponent bits 62:52, fraction bits 51:0). `in_dbl`=0 selects single precision (sign bit 31, exponent bits 30:23, fraction bits 22:0). In single mode, bits 63:32 have no effect on any output. `out_sign` equals the selected sign bit.
- R3: A double-precision normal input with exponent field e (1..2046) gives `out_exp` = e+1024 and `out_mant` = the 52-bit fraction, with all class flags low.
- R4: A single-precision normal input with exponent field e (1..254) gives `out_exp` = e+1920 and `out_mant` = fraction shifted left by 29, with all class flags low.
- R5: A double-precision subnormal input gives `out_exp` = 1024−z and `out_mant` = fraction shifted left by z+1, truncated to 52 bits. Here z is the number of leading zeros of the 52-bit fraction.
- R6: A single-precision subnormal input gives `out_exp` = 1920−z and `out_mant` = (fraction shifted left by 29) shifted left by z+1, truncated to 52 bits. Here z is the number of leading zeros of the 23-bit fraction.
- R7: An input of either sign that is zero gives `out_exp` = 0, `out_mant` = 0 and `out_zero` = 1, with the other flags low.
- R8: An infinity gives `out_exp` = 4095, `out_mant` = 0 and `out_inf` = 1, with the other flags low.
- R9: A NaN gives `out_exp` = 4095 and `out_mant` = the left-aligned fraction. `out_qnan` = 1 when bit 51 of that field is 1; otherwise `out_snan` = 1.
- R10: At most one class flag is high. A valid result with no flag high has `out_exp` strictly between 0 and 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_dbl | input | 1 | 1 = double precision, 0 = single precision |
| in_data | input | 64 | Operand bits (single uses bits 31:0) |
| out_valid | output | 1 | Result present |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | 12 | Internal exponent, bias 2047 |
| out_mant | output | 52 | Internal fraction, hidden one implied |
| out_zero | output | 1 | Operand was zero |
| out_inf | output | 1 | Operand was infinity |
| out_qnan | output | 1 | Operand was a quiet NaN |
| out_snan | output | 1 | Operand was a signalling NaN |

## Verification
Every result of this block falls due exactly one rising edge after its operand is presented. This applies to the sign, exponent, fraction and class flags alike, and `out_valid` drops one edge after `in_valid` drops. The bench drives each operand on a falling edge and reads all outputs at the following falling edge, half a period after the register has loaded. It then confirms that `out_valid` has cleared one edge after that. Expected fields come from a reference computed in the bench from the requirement formulas, including a leading-zero count for subnormals of both widths.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;

    // internal widened format
    localparam int X_EXP_W  = 12;
    localparam int X_MAN_W  = 52;
    localparam int X_BIAS   = (1 << (X_EXP_W - 1)) - 1;

    // external formats
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int IN_W     = 1 + DP_EXP_W + DP_MAN_W;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_SUB,
        CL_NORM,
        CL_INF,
        CL_NAN
    } fpx_class_e;

    // raw split of an operand, exponent already moved to the internal bias
    typedef struct packed {
        logic                 sign;
        fpx_class_e           cls;
        logic [X_EXP_W-1:0]   exp;
        logic [X_MAN_W-1:0]   mant;
    } fpx_split_t;

    // final internal operand
    typedef struct packed {
        logic                 sign;
        logic [X_EXP_W-1:0]   exp;
        logic [X_MAN_W-1:0]   mant;
        logic                 is_zero;
        logic                 is_inf;
        logic                 is_qnan;
        logic                 is_snan;
    } fpx_unpacked_t;

    // amount added to a source exponent to reach the internal bias
    function automatic int rebias_offset(input int src_exp_w);
        return X_BIAS - ((1 << (src_exp_w - 1)) - 1);
    endfunction

endpackage

// File: rtl/fpx_field_split.sv
`timescale 1ns/1ps
module fpx_field_split
    import fpx_pkg::*;
#(
    parameter int EW = DP_EXP_W,
    parameter int MW = DP_MAN_W
) (
    input  logic [EW+MW:0] raw_i,
    output fpx_split_t     split_o
);
    localparam int RAW_W = 1 + EW + MW;
    localparam int OFF   = rebias_offset(EW);
    localparam int PAD_W = X_MAN_W - MW;

    logic [EW-1:0]      ex_f;
    logic [MW-1:0]      fr_f;
    logic [X_MAN_W-1:0] aligned;

    assign ex_f = raw_i[RAW_W-2 -: EW];
    assign fr_f = raw_i[MW-1:0];

    // left-align the fraction into the internal field
    generate
        if (PAD_W == 0) begin : g_full
            assign aligned = fr_f;
        end else begin : g_pad
            assign aligned = {fr_f, {PAD_W{1'b0}}};
        end
    endgenerate

    always_comb begin
        split_o.sign = raw_i[RAW_W-1];
        split_o.mant = aligned;
        if (ex_f == '0) begin
            if (fr_f == '0) begin
                split_o.cls = CL_ZERO;
                split_o.exp = '0;
            end else begin
                // base exponent before the leading-zero correction
                split_o.cls = CL_SUB;
                split_o.exp = X_EXP_W'(OFF);
            end
        end else if (&ex_f) begin
            split_o.cls = (fr_f == '0) ? CL_INF : CL_NAN;
            split_o.exp = '1;
        end else begin
            split_o.cls = CL_NORM;
            split_o.exp = X_EXP_W'(ex_f) + X_EXP_W'(OFF);
        end
    end

endmodule

// File: rtl/fpx_lzc.sv
`timescale 1ns/1ps
module fpx_lzc #(
    parameter int W    = 52,
    localparam int LZ_W = $clog2(W + 1)
) (
    input  logic [W-1:0]    vec_i,
    output logic [LZ_W-1:0] lz_o
);
    // the highest set bit wins because it is visited last
    always_comb begin
        lz_o = LZ_W'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                lz_o = LZ_W'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/fpx_normalize.sv
`timescale 1ns/1ps
module fpx_normalize
    import fpx_pkg::*;
(
    input  fpx_split_t    split_i,
    output fpx_unpacked_t res_o
);
    localparam int LZ_W = $clog2(X_MAN_W + 1);

    logic [LZ_W-1:0] lz;
    logic [LZ_W:0]   shamt;

    fpx_lzc #(.W(X_MAN_W)) u_lzc (
        .vec_i (split_i.mant),
        .lz_o  (lz)
    );

    // one extra place so the leading one drops into the hidden position
    assign shamt = {1'b0, lz} + (LZ_W + 1)'(1);

    always_comb begin
        res_o.sign    = split_i.sign;
        res_o.exp     = split_i.exp;
        res_o.mant    = split_i.mant;
        res_o.is_zero = 1'b0;
        res_o.is_inf  = 1'b0;
        res_o.is_qnan = 1'b0;
        res_o.is_snan = 1'b0;
        case (split_i.cls)
            CL_SUB: begin
                res_o.exp  = split_i.exp - X_EXP_W'(lz);
                res_o.mant = split_i.mant << shamt;
            end
            CL_ZERO: res_o.is_zero = 1'b1;
            CL_INF:  res_o.is_inf  = 1'b1;
            CL_NAN: begin
                res_o.is_qnan = split_i.mant[X_MAN_W-1];
                res_o.is_snan = ~split_i.mant[X_MAN_W-1];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fpx_unpack.sv
`timescale 1ns/1ps
module fpx_unpack
    import fpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_dbl,
    input  logic [IN_W-1:0]    in_data,
    output logic               out_valid,
    output logic               out_sign,
    output logic [X_EXP_W-1:0] out_exp,
    output logic [X_MAN_W-1:0] out_mant,
    output logic               out_zero,
    output logic               out_inf,
    output logic               out_qnan,
    output logic               out_snan
);
    fpx_split_t    sp_split;
    fpx_split_t    dp_split;
    fpx_split_t    sel_split;
    fpx_unpacked_t nxt;
    fpx_unpacked_t q;

    fpx_field_split #(.EW(SP_EXP_W), .MW(SP_MAN_W)) u_split_sp (
        .raw_i   (in_data[SP_W-1:0]),
        .split_o (sp_split)
    );

    fpx_field_split #(.EW(DP_EXP_W), .MW(DP_MAN_W)) u_split_dp (
        .raw_i   (in_data),
        .split_o (dp_split)
    );

    assign sel_split = in_dbl ? dp_split : sp_split;

    fpx_normalize u_norm (
        .split_i (sel_split),
        .res_o   (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q         <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                q <= nxt;
            end
        end
    end

    assign out_sign = q.sign;
    assign out_exp  = q.exp;
    assign out_mant = q.mant;
    assign out_zero = q.is_zero;
    assign out_inf  = q.is_inf;
    assign out_qnan = q.is_qnan;
    assign out_snan = q.is_snan;

endmodule

// File: rtl/fpx_unpack_chk.sv
`timescale 1ns/1ps
module fpx_unpack_chk
    import fpx_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_dbl,
    input logic [IN_W-1:0]    in_data,
    input logic               out_valid,
    input logic               out_sign,
    input logic [X_EXP_W-1:0] out_exp,
    input logic [X_MAN_W-1:0] out_mant,
    input logic               out_zero,
    input logic               out_inf,
    input logic               out_qnan,
    input logic               out_snan
);
    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    sign_src_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_sign == $past(in_dbl ? in_data[63] : in_data[31]));

    // R7
    zero_enc_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_zero) |-> (out_exp == '0 && out_mant == '0));

    // R8
    inf_enc_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_inf) |-> (out_exp == '1 && out_mant == '0));

    // R9
    nan_enc_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_qnan || out_snan)) |->
        (out_exp == '1 && out_mant != '0 && out_mant[X_MAN_W-1] == out_qnan));

    // R10
    cls_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_zero, out_inf, out_qnan, out_snan}));

    // R10
    finite_rng_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_zero || out_inf || out_qnan || out_snan)) |->
        (out_exp != '0 && out_exp != '1));

endmodule

bind fpx_unpack fpx_unpack_chk i_chk (.*);

// File: tb/test_fpx_unpack.sv
`timescale 1ns/1ps
module test_fpx_unpack;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_dbl = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid, out_sign, out_zero, out_inf, out_qnan, out_snan;
    logic [11:0] out_exp;
    logic [51:0] out_mant;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fpx_unpack i_fpx_unpack (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dbl(in_dbl),
        .in_data(in_data), .out_valid(out_valid), .out_sign(out_sign),
        .out_exp(out_exp), .out_mant(out_mant), .out_zero(out_zero),
        .out_inf(out_inf), .out_qnan(out_qnan), .out_snan(out_snan)
    );

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // expected fields computed from the requirement formulas
    task automatic ref_unpack(input logic dbl, input logic [63:0] d,
                              output logic s, output logic [11:0] ex,
                              output logic [51:0] m, output logic [3:0] fl);
        int e, emax, off, lz;
        logic [51:0] al;
        fl = 4'b0000; // {zero, inf, qnan, snan}
        if (dbl) begin
            s = d[63]; e = int'(d[62:52]); al = d[51:0]; emax = 2047; off = 1024;
        end else begin
            s = d[31]; e = int'(d[30:23]); al = {d[22:0], 29'b0}; emax = 255; off = 1920;
        end
        if (e == 0 && al == '0) begin
            ex = '0; m = '0; fl = 4'b1000;
        end else if (e == 0) begin
            lz = 0;
            while (!al[51 - lz]) lz++;
            ex = 12'(off - lz);
            m  = al << (lz + 1);
        end else if (e == emax) begin
            ex = 12'hfff; m = al;
            if (al == '0) fl = 4'b0100;
            else if (al[51]) fl = 4'b0010;
            else fl = 4'b0001;
        end else begin
            ex = 12'(e + off); m = al;
        end
    endtask

    task automatic run_one(input string req, input logic dbl, input logic [63:0] d);
        logic s; logic [11:0] ex; logic [51:0] m; logic [3:0] fl;
        ref_unpack(dbl, d, s, ex, m, fl);
        @(negedge clk);
        in_valid = 1'b1; in_dbl = dbl; in_data = d;
        @(negedge clk);
        in_valid = 1'b0; in_data = '0;
        check({req, " valid"}, 128'(out_valid), 128'(1'b1));
        check({req, " sign"},  128'(out_sign), 128'(s));
        check({req, " exp"},   128'(out_exp), 128'(ex));
        check({req, " mant"},  128'(out_mant), 128'(m));
        check({req, " flags"}, 128'({out_zero, out_inf, out_qnan, out_snan}), 128'(fl));
    endtask

    task automatic t_reset();
        check("R1 reset valid", 128'(out_valid), 128'(0));
        check("R1 reset fields", 128'({out_sign, out_exp, out_mant, out_zero,
              out_inf, out_qnan, out_snan}), 128'(0));
    endtask

    task automatic t_latency();
        run_one("R1 latency", 1'b1, 64'h3FF0_0000_0000_0000);
        @(negedge clk);
        check("R1 valid drops", 128'(out_valid), 128'(0));
    endtask

    task automatic t_dbl_normal();
        run_one("R3 one", 1'b1, 64'h3FF0_0000_0000_0000);
        run_one("R3 max", 1'b1, 64'hFFEF_FFFF_FFFF_FFFF);
        run_one("R3 min", 1'b1, 64'h0010_0000_0000_0001);
    endtask

    task automatic t_sgl_normal();
        run_one("R4 one", 1'b0, 64'h0000_0000_3F80_0000);
        run_one("R4 max", 1'b0, 64'h0000_0000_FF7F_FFFF);
        run_one("R4 min", 1'b0, 64'h0000_0000_0080_0001);
    endtask

    task automatic t_dbl_sub();
        run_one("R5 lsb", 1'b1, 64'h0000_0000_0000_0001);
        run_one("R5 msb", 1'b1, 64'h8008_0000_0000_0003);
        run_one("R5 mid", 1'b1, 64'h0000_0123_4567_89AB);
    endtask

    task automatic t_sgl_sub();
        run_one("R6 lsb", 1'b0, 64'h0000_0000_0000_0001);
        run_one("R6 msb", 1'b0, 64'h0000_0000_8040_0005);
        run_one("R6 mid", 1'b0, 64'h0000_0000_0001_2345);
    endtask

    task automatic t_upper_ignored();
        run_one("R2 upper ignored", 1'b0, 64'hFFFF_FFFF_3F80_0000);
        run_one("R2 sign single", 1'b0, 64'h0000_0000_C000_0000);
        run_one("R2 sign double", 1'b1, 64'hC000_0000_0000_0000);
    endtask

    task automatic t_specials();
        run_one("R7 dbl +0", 1'b1, 64'h0000_0000_0000_0000);
        run_one("R7 sgl -0", 1'b0, 64'h0000_0000_8000_0000);
        run_one("R8 dbl -inf", 1'b1, 64'hFFF0_0000_0000_0000);
        run_one("R8 sgl +inf", 1'b0, 64'h0000_0000_7F80_0000);
        run_one("R9 dbl qnan", 1'b1, 64'h7FF8_0000_0000_0000);
        run_one("R9 dbl snan", 1'b1, 64'h7FF0_0000_0000_0001);
        run_one("R9 sgl qnan", 1'b0, 64'h0000_0000_FFC0_0001);
        run_one("R9 sgl snan", 1'b0, 64'h0000_0000_7F80_0001);
    endtask

    task automatic t_mixed();
        for (int k = 0; k < 200; k++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            if (k % 4 == 1) d[62:52] = '0;
            if (k % 4 == 3) d[30:23] = '0;
            run_one("R10 mixed", k[0], d);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_latency();
        t_dbl_normal();
        t_sgl_normal();
        t_dbl_sub();
        t_sgl_sub();
        t_upper_ignored();
        t_specials();
        t_mixed();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule